// File: doc/BRIEF.md
# Serial Link Mode and SYNC Insertion Controller

This block sits in front of a parallel-to-serial transmitter. Two static, active-low strap inputs select one of four framing modes: a back-channel link-status mode, a DC-balanced line-code mode, both, or neither. From the selected mode the block drives mode flags, a lane-alignment enable, and the default enables for the scrambler and the NRZI stage. It also registers the parallel lanes on their way to the serializer. For each word it chooses either the data or a SYNC character.

With DC balancing on, only the four low lanes carry payload. The top lane becomes a data-valid strobe, and each cycle it is high forces a SYNC word. When the link comes up in DC-balance-only mode, the strobe must stay high for 110 consecutive clocks before the link is reported ready. A drop inside that window raises a sticky violation flag. With the back-channel on, the block instead requests a training pattern and waits for an acknowledge. In DC-balance-only mode the receiver has no way to report that it lost lock. For that case a programmable timer can insert short bursts of SYNC words at regular intervals.

Top module: `link_sync_ctrl`

## Requirements
- R1: While `rst_n` is low, every output is 0. The straps are sampled on the first clock edge after reset release. From that edge on, `mode_rsense` equals the inverse of `cfg_rsense_n` and `mode_dcbal` equals the inverse of `cfg_dcbal_n`.
- R2: `lane_align_en` is 1 when at least one of the two features is on. `scram_en` and `nrzi_en` are 1 only when exactly one of the two features is on.
- R3: With DC balancing on and no SYNC chosen, `data_out[3:0]` equals `lane_in[3:0]` from the previous cycle. `data_out[4]` is always 0 in this mode.
- R4: With DC balancing on, if `lane_in[4]` is 1 in a cycle, then on the next cycle `sym_sync` is 1 and `data_out` is all zero.
- R5: With DC balancing off, `data_out` equals the previous cycle's `lane_in` on all five lanes, and `sym_sync` stays 0.
- R6: In DC-balance-only mode, the hold phase begins on the sampling edge. `link_ready` rises on the edge that completes 110 consecutive hold-phase cycles with `lane_in[4]` high.
- R7: In the hold phase, `lane_in[4]` may fall after it has been high in that phase. If it falls before the 110-cycle hold completes, `linkup_viol` becomes 1 on the next cycle and the hold count restarts. A low strobe before any high cycle is not flagged. `linkup_viol` stays 1 until the next strap sampling, which clears it.
- R8: When the back-channel feature is on, `train_req` is 1 from the sampling edge until `train_ack` is seen high. On the following cycle `link_ready` is 1 and `train_req` is 0.
- R9: With both features off, `link_ready` is 1 from the cycle after the sampling edge.
- R10: In DC-balance-only mode with `link_ready` high and `resync_period` = P nonzero, `sym_sync` repeats a pattern of P cycles low followed by `resync_len` cycles high. The first burst is visible 6 cycles after P = 5 is applied from an idle counter. With P = 0 no bursts occur.
- R11: A pulse on `link_restart`, or a strap value that differs from the latched mode, drops `link_ready` on the next edge. The straps are resampled on the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rsense_n | input | 1 | Back-channel feature strap, active low |
| cfg_dcbal_n | input | 1 | DC-balance feature strap, active low |
| link_restart | input | 1 | Restart link bring-up and resample the straps |
| train_ack | input | 1 | Training pattern acknowledged |
| lane_in | input | 5 | Parallel lanes; top lane is the data-valid strobe when DC balancing is on |
| resync_period | input | 16 | Idle cycles between resync bursts, 0 disables |
| resync_len | input | 8 | SYNC cycles per resync burst |
| data_out | output | 5 | Registered lanes toward the serializer |
| sym_sync | output | 1 | Registered select: 1 = send a SYNC character |
| mode_rsense | output | 1 | Back-channel feature active |
| mode_dcbal | output | 1 | DC-balance feature active |
| lane_align_en | output | 1 | Lane alignment enable |
| scram_en | output | 1 | Scrambler default enable |
| nrzi_en | output | 1 | NRZI default enable |
| train_req | output | 1 | Training pattern request |
| link_ready | output | 1 | Link bring-up complete |
| linkup_viol | output | 1 | Sticky hold-window violation |

## Verification
The lane path has one register stage, so `data_out` and `sym_sync` are due one edge after the lane values that produce them. The bench drives each input at a falling edge and compares one clock later. A strap change or restart takes two edges before the new mode flags appear: one edge to enter sampling and one to latch. Reset release takes one edge. The hold completion is checked at both neighbours of the 110th high edge, so both an early and a late ready are caught. The first resync burst shows up six edges after the period is set. Because of this, the bursts are aligned to their measured first rise before the low/high pattern is compared.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [1:0] {
        ST_SAMPLE = 2'd0,
        ST_HOLD   = 2'd1,
        ST_TRAIN  = 2'd2,
        ST_READY  = 2'd3
    } lsc_state_e;

    typedef struct packed {
        logic rs_on;
        logic dcb_on;
    } lsc_mode_t;

    function automatic lsc_mode_t lsc_decode(input logic rs_n, input logic dcb_n);
        lsc_mode_t m;
        m.rs_on  = ~rs_n;
        m.dcb_on = ~dcb_n;
        return m;
    endfunction

endpackage

// File: rtl/lsc_link_fsm.sv
module lsc_link_fsm
    import lsc_pkg::*;
#(
    parameter int HOLD_CYCLES = 110
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rs_n,
    input  logic      dcb_n,
    input  logic      restart,
    input  logic      dv,
    input  logic      train_ack,
    output lsc_mode_t mode,
    output logic      ready,
    output logic      train_req,
    output logic      viol,
    output logic      timer_run
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        lsc_state_e     st;
        lsc_mode_t      mode;
        logic [CW-1:0]  cnt;
        logic           viol;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;
    lsc_mode_t pins_mode;

    always_comb begin
        pins_mode = lsc_decode(rs_n, dcb_n);
        r_d = r_q;
        case (r_q.st)
            ST_SAMPLE: begin
                r_d.mode = pins_mode;
                r_d.cnt  = '0;
                r_d.viol = 1'b0;
                if (pins_mode.rs_on)       r_d.st = ST_TRAIN;
                else if (pins_mode.dcb_on) r_d.st = ST_HOLD;
                else                       r_d.st = ST_READY;
            end
            ST_HOLD: begin
                if (dv) begin
                    if (r_q.cnt == CW'(HOLD_CYCLES - 1)) begin
                        r_d.cnt = '0;
                        r_d.st  = ST_READY;
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end else if (r_q.cnt != '0) begin
                    r_d.viol = 1'b1;
                    r_d.cnt  = '0;
                end
            end
            ST_TRAIN: begin
                if (train_ack) r_d.st = ST_READY;
            end
            default: ;
        endcase
        if (r_q.st != ST_SAMPLE && (restart || pins_mode != r_q.mode))
            r_d.st = ST_SAMPLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_SAMPLE, mode: '0, cnt: '0, viol: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mode      = r_q.mode;
    assign ready     = (r_q.st == ST_READY);
    assign train_req = (r_q.st == ST_TRAIN);
    assign viol      = r_q.viol;
    assign timer_run = ready && r_q.mode.dcb_on && !r_q.mode.rs_on;

    AST_HOLD_ENDS_ON_DV: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && mode.dcb_on && !mode.rs_on) |-> $past(dv)); // R6
    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (viol && r_q.st != ST_SAMPLE) |=> viol); // R7
    AST_TRAIN_WAITS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (train_req && !train_ack) |=> !ready); // R8
    AST_RESTART_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && r_q.st != ST_SAMPLE) |=> !ready); // R11

endmodule

// File: rtl/lsc_resync_timer.sv
module lsc_resync_timer #(
    parameter int PERIOD_W = 16,
    parameter int BURST_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [PERIOD_W-1:0] period,
    input  logic [BURST_W-1:0]  burst_len,
    output logic                force_sync
);
    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
        logic [BURST_W-1:0]  left;
    } tmr_regs_t;

    tmr_regs_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!run) begin
            t_d.cnt  = '0;
            t_d.left = '0;
        end else if (t_q.left != '0) begin
            t_d.left = t_q.left - BURST_W'(1);
        end else if (period != '0) begin
            if (t_q.cnt == period - PERIOD_W'(1)) begin
                t_d.cnt  = '0;
                t_d.left = burst_len;
            end else begin
                t_d.cnt = t_q.cnt + PERIOD_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign force_sync = (t_q.left != '0);

    AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !force_sync); // R10

endmodule

// File: rtl/lsc_lane_path.sv
module lsc_lane_path #(
    parameter int LANES = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dcb_on,
    input  logic             force_sync,
    input  logic [LANES-1:0] lane_in,
    output logic [LANES-1:0] data_out,
    output logic             sym_sync
);
    localparam int DV_BIT = LANES - 1;

    typedef struct packed {
        logic [LANES-1:0] data;
        logic             sync;
    } lane_regs_t;

    lane_regs_t l_d, l_q;

    always_comb begin
        if (dcb_on) begin
            l_d.sync = lane_in[DV_BIT] | force_sync;
            l_d.data = l_d.sync ? '0 : {1'b0, lane_in[DV_BIT-1:0]};
        end else begin
            l_d.sync = 1'b0;
            l_d.data = lane_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign data_out = l_q.data;
    assign sym_sync = l_q.sync;

endmodule

// File: rtl/link_sync_ctrl.sv
module link_sync_ctrl
    import lsc_pkg::*;
#(
    parameter int DATA_LANES  = 4,
    parameter int HOLD_CYCLES = 110,
    parameter int PERIOD_W    = 16,
    parameter int BURST_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_rsense_n,
    input  logic                  cfg_dcbal_n,
    input  logic                  link_restart,
    input  logic                  train_ack,
    input  logic [DATA_LANES:0]   lane_in,
    input  logic [PERIOD_W-1:0]   resync_period,
    input  logic [BURST_W-1:0]    resync_len,
    output logic [DATA_LANES:0]   data_out,
    output logic                  sym_sync,
    output logic                  mode_rsense,
    output logic                  mode_dcbal,
    output logic                  lane_align_en,
    output logic                  scram_en,
    output logic                  nrzi_en,
    output logic                  train_req,
    output logic                  link_ready,
    output logic                  linkup_viol
);
    localparam int LANES = DATA_LANES + 1;

    lsc_mode_t mode;
    logic      timer_run;
    logic      force_sync;

    lsc_link_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rs_n      (cfg_rsense_n),
        .dcb_n     (cfg_dcbal_n),
        .restart   (link_restart),
        .dv        (lane_in[DATA_LANES]),
        .train_ack (train_ack),
        .mode      (mode),
        .ready     (link_ready),
        .train_req (train_req),
        .viol      (linkup_viol),
        .timer_run (timer_run)
    );

    lsc_resync_timer #(.PERIOD_W(PERIOD_W), .BURST_W(BURST_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (timer_run),
        .period     (resync_period),
        .burst_len  (resync_len),
        .force_sync (force_sync)
    );

    lsc_lane_path #(.LANES(LANES)) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .dcb_on     (mode.dcb_on),
        .force_sync (force_sync),
        .lane_in    (lane_in),
        .data_out   (data_out),
        .sym_sync   (sym_sync)
    );

    assign mode_rsense   = mode.rs_on;
    assign mode_dcbal    = mode.dcb_on;
    assign lane_align_en = mode.rs_on | mode.dcb_on;
    assign scram_en      = mode.rs_on ^ mode.dcb_on;
    assign nrzi_en       = mode.rs_on ^ mode.dcb_on;

    AST_DV_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_dcbal) |-> !data_out[DATA_LANES]); // R3
    AST_SYNC_ON_DV: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_dcbal) && $past(lane_in[DATA_LANES])) |-> (sym_sync && data_out == '0)); // R4
    AST_RAW_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mode_dcbal) |-> !sym_sync); // R5
    AST_READY_XOR_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({link_ready, train_req})); // R8

endmodule

// File: tb/link_sync_ctrl_tb_top.sv
module link_sync_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_rsense_n, cfg_dcbal_n, link_restart, train_ack;
    logic [4:0]  lane_in;
    logic [15:0] resync_period;
    logic [7:0]  resync_len;
    logic [4:0]  data_out;
    logic        sym_sync, mode_rsense, mode_dcbal, lane_align_en;
    logic        scram_en, nrzi_en, train_req, link_ready, linkup_viol;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    link_sync_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_rsense_n(cfg_rsense_n), .cfg_dcbal_n(cfg_dcbal_n),
        .link_restart(link_restart), .train_ack(train_ack), .lane_in(lane_in),
        .resync_period(resync_period), .resync_len(resync_len), .data_out(data_out),
        .sym_sync(sym_sync), .mode_rsense(mode_rsense), .mode_dcbal(mode_dcbal),
        .lane_align_en(lane_align_en), .scram_en(scram_en), .nrzi_en(nrzi_en),
        .train_req(train_req), .link_ready(link_ready), .linkup_viol(linkup_viol)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // {rsense, dcbal, align, scram, nrzi}
    function automatic logic [4:0] exp_flags(input logic rs_n, input logic dcb_n);
        logic rs, db;
        rs = ~rs_n;
        db = ~dcb_n;
        return {rs, db, rs | db, rs ^ db, rs ^ db};
    endfunction

    function automatic logic [5:0] exp_lane(input logic [4:0] ln, input logic dcb);
        if (!dcb)      return {1'b0, ln};
        else if (ln[4]) return {1'b1, 5'b0};
        else           return {1'b0, 1'b0, ln[3:0]};
    endfunction

    task automatic set_pins(input logic rs_n, input logic dcb_n);
        cfg_rsense_n = rs_n;
        cfg_dcbal_n  = dcb_n;
        tick(2);
        chk("R1/R2 flags", {mode_rsense, mode_dcbal, lane_align_en, scram_en, nrzi_en},
            exp_flags(rs_n, dcb_n));
    endtask

    task automatic rand_lanes(input int n, input logic dcb, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            logic [4:0] v;
            v = 5'($urandom());
            lane_in = v;
            tick(1);
            if ({sym_sync, data_out} !== exp_lane(v, dcb)) begin
                bad++;
                if (bad == 1) chk(req, {sym_sync, data_out}, exp_lane(v, dcb));
            end
        end
        if (bad == 0) chk(req, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0; cfg_rsense_n = 1; cfg_dcbal_n = 0; link_restart = 0; train_ack = 0;
        lane_in = 0; resync_period = 0; resync_len = 0;
        tick(3);
        chk("R1 reset outputs", {data_out, sym_sync, mode_rsense, mode_dcbal, lane_align_en,
            scram_en, nrzi_en, train_req, link_ready, linkup_viol}, 0);
        rst_n = 1;
        tick(1);
        chk("R1 flags after release", {mode_rsense, mode_dcbal, lane_align_en, scram_en, nrzi_en},
            exp_flags(1'b1, 1'b0));

        // hold phase, strobe low before any high: no violation (R7)
        tick(5);
        chk("R7 no viol before rise", {linkup_viol, link_ready}, 0);
        lane_in = 5'b10000;
        tick(50);
        lane_in = 5'b00000;
        tick(1);
        chk("R7 viol on early drop", {linkup_viol, link_ready}, 2'b10);
        lane_in = 5'b10000;
        tick(109);
        chk("R6 not ready at 109", link_ready, 0);
        tick(1);
        chk("R6 ready at 110", link_ready, 1);
        chk("R7 viol sticky", linkup_viol, 1);

        // resync timer (R10)
        lane_in = 0;
        resync_len = 8'd3;
        resync_period = 16'd5;
        begin
            int first = -1;
            int bad = 0;
            logic [39:0] seq;
            for (int i = 1; i <= 40; i++) begin
                tick(1);
                seq[i-1] = sym_sync;
                if (sym_sync && first < 0) first = i;
            end
            chk("R10 first burst at 6", first, 6);
            for (int j = 0; j < 30; j++)
                if (seq[first - 1 + j] !== ((j % 8) < 3)) bad++;
            chk("R10 burst pattern", bad, 0);
        end
        resync_period = 0;
        tick(10);
        begin
            int hi = 0;
            for (int i = 0; i < 20; i++) begin
                tick(1);
                if (sym_sync) hi++;
            end
            chk("R10 period zero disables", hi, 0);
        end

        rand_lanes(200, 1'b1, "R3/R4 dcbal lanes");

        // both features off (R9, R11)
        cfg_rsense_n = 1; cfg_dcbal_n = 1;
        tick(1);
        chk("R11 ready drops on pin change", link_ready, 0);
        tick(1);
        chk("R9 raw ready", link_ready, 1);
        chk("R1/R2 raw flags", {mode_rsense, mode_dcbal, lane_align_en, scram_en, nrzi_en},
            exp_flags(1'b1, 1'b1));
        rand_lanes(200, 1'b0, "R5 raw lanes");

        // both features on (R8)
        lane_in = 0;
        set_pins(1'b0, 1'b0);
        chk("R8 train requested", {train_req, link_ready}, 2'b10);
        tick(5);
        chk("R8 waits for ack", {train_req, link_ready}, 2'b10);
        train_ack = 1;
        tick(1);
        train_ack = 0;
        chk("R8 ready after ack", {train_req, link_ready}, 2'b01);
        rand_lanes(100, 1'b1, "R4 lanes with back-channel");

        // back-channel only, then restart (R2, R11)
        lane_in = 0;
        set_pins(1'b0, 1'b1);
        train_ack = 1;
        tick(1);
        train_ack = 0;
        chk("R8 ready rs-only", link_ready, 1);
        link_restart = 1;
        tick(1);
        link_restart = 0;
        chk("R11 restart drops ready", link_ready, 0);
        tick(1);
        chk("R11 retrains after restart", {train_req, link_ready}, 2'b10);

        // violation cleared by resampling (R7)
        set_pins(1'b1, 1'b0);
        lane_in = 5'b10000;
        tick(3);
        lane_in = 0;
        tick(1);
        chk("R7 viol set", linkup_viol, 1);
        link_restart = 1;
        tick(1);
        link_restart = 0;
        tick(1);
        chk("R7 viol cleared by resample", linkup_viol, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule